// File: doc/BRIEF.md
# String Repeat Iteration Controller

This block sequences a string instruction that carries a repeat prefix. On a start request it captures the prefix code, the compare-type flag, the address size and the current count register. It then issues one execute request per iteration to an external datapath and waits for that datapath's completion strobe. Together with the completion strobe, the datapath returns the zero flag of the iteration and whether an asynchronous event is pending. After each iteration the controller decrements the count field. It finishes with a one-cycle done pulse carrying a status code and the count value to write back.

The loop has three exits. It can run the count down to zero. For compare-type operations it can stop on the zero-flag condition. It can also yield to a pending event (or to a forced single-step mode), in which case it asks the core to rewind the instruction pointer to the start of the instruction and flags that trace execution must stop. A repeat that yields in this way is resumed later, starting from the count it wrote back.

Top module: `rep_iter_ctrl`

## Requirements
- R1: With prefix code 0 (none), the operation is requested exactly once, whatever the count. The done status is 0 (completed) and `cnt_wb_valid_o` stays low.
- R2: With a repeat prefix (codes 1 to 3) and a count field of zero at start, no execute request is issued. Done reports status 0 with the count written back unchanged.
- R3: With a nonzero count field N and no other exit condition, exactly N execute requests are issued, and the written-back count field is zero.
- R4: Address size 0 (16-bit) tests and decrements only bits 15:0. Bits above 15 are written back unchanged.
- R5: Address size 1 (32-bit) tests and decrements bits 31:0. The write-back is that 32-bit result zero-extended to the full register.
- R6: Address size 2 (64-bit) tests and decrements the full register.
- R7: With the compare flag set, prefix code 3 ends the loop with status 1 (zf_terminated) after the first iteration that returns ZF=0. With the compare flag clear, ZF is ignored.
- R8: With the compare flag set, prefix code 2 ends the loop with status 1 after the first iteration that returns ZF=1.
- R9: The zero-flag exit is evaluated before the count reaching zero. If both occur on one iteration, the status is 1.
- R10: An event pending at the end of an iteration that did not finish the loop ends it with status 2 (preempted). In that case `rewind_ip_o` and `stop_trace_o` are high with done, and the written-back count reflects the iterations completed.
- R11: An event pending on the iteration that finishes the loop has no effect. Status is 0, and `stop_trace_o` and `rewind_ip_o` stay low.
- R12: With `dbg_step_i` high, the loop is preempted after every iteration that does not finish it.
- R13: A start request while busy is ignored. The running loop's iteration count and write-back are unaffected.
- R14: `done_o` is a single-cycle pulse. `exec_req_o` is high only while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a new instruction (ignored while busy) |
| rep_code_i | input | 2 | Prefix: 0 none, 1 plain repeat, 2 repeat-while-not-equal, 3 repeat-while-equal |
| cmp_op_i | input | 1 | Operation is compare-type (zero-flag exits enabled) |
| asize_i | input | 2 | Address size: 0 16-bit, 1 32-bit, 2 or 3 64-bit |
| count_i | input | CNT_W | Count register value at start |
| exec_req_o | output | 1 | Request one execution of the string operation |
| exec_done_i | input | 1 | Datapath finished the requested iteration |
| zf_i | input | 1 | Zero flag of that iteration, valid with exec_done_i |
| event_pend_i | input | 1 | Asynchronous event pending, sampled with exec_done_i |
| dbg_step_i | input | 1 | Force exit after every iteration |
| busy_o | output | 1 | Loop in progress |
| done_o | output | 1 | One-cycle end pulse |
| status_o | output | 2 | 0 completed, 1 zf_terminated, 2 preempted |
| rewind_ip_o | output | 1 | Restore instruction pointer to instruction start |
| stop_trace_o | output | 1 | Stop-trace indication |
| cnt_wb_valid_o | output | 1 | Count write-back valid (with done) |
| cnt_wb_o | output | CNT_W | Count register value to write back |

## Verification
The interesting collisions are the exits that can land on the same iteration. One case is a zero-flag mismatch on the iteration that brings the count to zero. The other is an event that is pending as the final iteration completes. The bench programs the datapath responder so that it returns the chosen ZF and event values on exactly that iteration. It then judges the status code, the trace and rewind outputs, and the written-back count against the priority order: zero-flag first, then count exhausted, then event.

// File: rtl/rep_iter_pkg.sv
package rep_iter_pkg;
  typedef enum logic [1:0] {AS_16 = 2'd0, AS_32 = 2'd1, AS_64 = 2'd2, AS_64B = 2'd3} asize_e;
  typedef enum logic [1:0] {ST_DONE = 2'd0, ST_ZF = 2'd1, ST_PREEMPT = 2'd2} status_e;
  typedef enum logic [1:0] {DEC_CONT, DEC_OK, DEC_ZF, DEC_PRE} decide_e;
  typedef enum logic [1:0] {S_IDLE, S_CHECK, S_EXEC} state_e;

  localparam logic [1:0] RC_NONE  = 2'd0;
  localparam logic [1:0] RC_PLAIN = 2'd1;
  localparam logic [1:0] RC_NE    = 2'd2;
  localparam logic [1:0] RC_EQ    = 2'd3;
endpackage

// File: rtl/rep_cnt_unit.sv
module rep_cnt_unit
  import rep_iter_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [1:0]       asize_i,
  output logic             fld_zero_o,
  output logic [CNT_W-1:0] dec_o,
  output logic             dec_zero_o
);
  localparam int LO16 = 16;
  localparam int LO32 = 32;

  logic [LO16-1:0]  d16;
  logic [LO32-1:0]  d32;
  logic [CNT_W-1:0] d64;
  logic [CNT_W-1:0] ext16;
  logic [CNT_W-1:0] ext32;

  assign d16 = cnt_i[LO16-1:0] - 16'd1;
  assign d32 = cnt_i[LO32-1:0] - 32'd1;
  assign d64 = cnt_i - {{(CNT_W-1){1'b0}}, 1'b1};

  assign ext16 = {cnt_i[CNT_W-1:LO16], d16};

  generate
    if (CNT_W > LO32) begin : g_wide
      assign ext32 = {{(CNT_W-LO32){1'b0}}, d32};
    end else begin : g_narrow
      assign ext32 = d32;
    end
  endgenerate

  always_comb begin
    unique case (asize_i)
      AS_16: begin
        fld_zero_o = (cnt_i[LO16-1:0] == '0);
        dec_o      = ext16;
        dec_zero_o = (d16 == '0);
      end
      AS_32: begin
        fld_zero_o = (cnt_i[LO32-1:0] == '0);
        dec_o      = ext32;
        dec_zero_o = (d32 == '0);
      end
      default: begin
        fld_zero_o = (cnt_i == '0);
        dec_o      = d64;
        dec_zero_o = (d64 == '0);
      end
    endcase
  end
endmodule

// File: rtl/rep_exit_eval.sv
module rep_exit_eval
  import rep_iter_pkg::*;
(
  input  logic       single_i,
  input  logic [1:0] rep_code_i,
  input  logic       cmp_op_i,
  input  logic       zf_i,
  input  logic       dec_zero_i,
  input  logic       event_i,
  input  logic       dbg_step_i,
  output decide_e    decide_o
);
  logic zf_stop;

  always_comb begin
    zf_stop = 1'b0;
    if (cmp_op_i) begin
      if (rep_code_i == RC_EQ && !zf_i) zf_stop = 1'b1;
      if (rep_code_i == RC_NE &&  zf_i) zf_stop = 1'b1;
    end
  end

  // Exit priority: single shot, zero flag, count exhausted, event.
  always_comb begin
    if (single_i)                    decide_o = DEC_OK;
    else if (zf_stop)                decide_o = DEC_ZF;
    else if (dec_zero_i)             decide_o = DEC_OK;
    else if (event_i || dbg_step_i)  decide_o = DEC_PRE;
    else                             decide_o = DEC_CONT;
  end
endmodule

// File: rtl/rep_iter_ctrl.sv
module rep_iter_ctrl
  import rep_iter_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [1:0]       rep_code_i,
  input  logic             cmp_op_i,
  input  logic [1:0]       asize_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             exec_req_o,
  input  logic             exec_done_i,
  input  logic             zf_i,
  input  logic             event_pend_i,
  input  logic             dbg_step_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [1:0]       status_o,
  output logic             rewind_ip_o,
  output logic             stop_trace_o,
  output logic             cnt_wb_valid_o,
  output logic [CNT_W-1:0] cnt_wb_o
);
  state_e           state_q, state_d;
  logic [1:0]       code_q, code_d;
  logic             cmp_q, cmp_d;
  logic [1:0]       as_q, as_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;
  logic [1:0]       status_q, status_d;
  logic             wbv_q, wbv_d;
  logic             rewind_q, rewind_d;
  logic             trace_q, trace_d;

  logic             fld_zero;
  logic [CNT_W-1:0] dec_val;
  logic             dec_zero;
  decide_e          decide;
  logic             single;

  assign single = (code_q == RC_NONE);

  rep_cnt_unit #(.CNT_W(CNT_W)) u_cnt (
    .cnt_i      (cnt_q),
    .asize_i    (as_q),
    .fld_zero_o (fld_zero),
    .dec_o      (dec_val),
    .dec_zero_o (dec_zero)
  );

  rep_exit_eval u_eval (
    .single_i   (single),
    .rep_code_i (code_q),
    .cmp_op_i   (cmp_q),
    .zf_i       (zf_i),
    .dec_zero_i (dec_zero),
    .event_i    (event_pend_i),
    .dbg_step_i (dbg_step_i),
    .decide_o   (decide)
  );

  always_comb begin
    state_d  = state_q;
    code_d   = code_q;
    cmp_d    = cmp_q;
    as_d     = as_q;
    cnt_d    = cnt_q;
    done_d   = 1'b0;
    status_d = status_q;
    wbv_d    = 1'b0;
    rewind_d = 1'b0;
    trace_d  = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (start_i) begin
          code_d  = rep_code_i;
          cmp_d   = cmp_op_i;
          as_d    = asize_i;
          cnt_d   = count_i;
          state_d = (rep_code_i == RC_NONE) ? S_EXEC : S_CHECK;
        end
      end
      S_CHECK: begin
        if (fld_zero) begin
          state_d  = S_IDLE;
          done_d   = 1'b1;
          status_d = ST_DONE;
          wbv_d    = 1'b1;
        end else begin
          state_d = S_EXEC;
        end
      end
      S_EXEC: begin
        if (exec_done_i) begin
          if (!single) cnt_d = dec_val;
          if (decide != DEC_CONT) begin
            state_d = S_IDLE;
            done_d  = 1'b1;
            wbv_d   = !single;
          end
          unique case (decide)
            DEC_ZF:  status_d = ST_ZF;
            DEC_PRE: begin
              status_d = ST_PREEMPT;
              rewind_d = 1'b1;
              trace_d  = 1'b1;
            end
            default: status_d = ST_DONE;
          endcase
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      code_q   <= RC_NONE;
      cmp_q    <= 1'b0;
      as_q     <= 2'd0;
      cnt_q    <= '0;
      done_q   <= 1'b0;
      status_q <= ST_DONE;
      wbv_q    <= 1'b0;
      rewind_q <= 1'b0;
      trace_q  <= 1'b0;
    end else begin
      state_q  <= state_d;
      code_q   <= code_d;
      cmp_q    <= cmp_d;
      as_q     <= as_d;
      cnt_q    <= cnt_d;
      done_q   <= done_d;
      status_q <= status_d;
      wbv_q    <= wbv_d;
      rewind_q <= rewind_d;
      trace_q  <= trace_d;
    end
  end

  assign exec_req_o     = (state_q == S_EXEC);
  assign busy_o         = (state_q != S_IDLE);
  assign done_o         = done_q;
  assign status_o       = status_q;
  assign rewind_ip_o    = rewind_q;
  assign stop_trace_o   = trace_q;
  assign cnt_wb_valid_o = wbv_q;
  assign cnt_wb_o       = cnt_q;
endmodule

// File: rtl/rep_iter_ctrl_chk.sv
module rep_iter_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       exec_req_o,
  input logic       busy_o,
  input logic       done_o,
  input logic [1:0] status_o,
  input logic       rewind_ip_o,
  input logic       stop_trace_o
);
  a_r14_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r14_req_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    exec_req_o |-> busy_o);

  a_r10_rewind_with_trace: assert property (@(posedge clk) disable iff (!rst_n)
    rewind_ip_o |-> (done_o && stop_trace_o && status_o == 2'd2));

  a_r11_trace_only_preempt: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && status_o != 2'd2) |-> (!stop_trace_o && !rewind_ip_o));

  a_r13_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
endmodule

bind rep_iter_ctrl rep_iter_ctrl_chk chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .exec_req_o   (exec_req_o),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .status_o     (status_o),
  .rewind_ip_o  (rewind_ip_o),
  .stop_trace_o (stop_trace_o)
);

// File: tb/rep_iter_ctrl_tb_top.sv
module rep_iter_ctrl_tb_top;
  localparam int CNT_W = 64;

  logic             clk;
  logic             rst_n;
  logic             start_i;
  logic [1:0]       rep_code_i;
  logic             cmp_op_i;
  logic [1:0]       asize_i;
  logic [CNT_W-1:0] count_i;
  logic             exec_req_o;
  logic             exec_done_i;
  logic             zf_i;
  logic             event_pend_i;
  logic             dbg_step_i;
  logic             busy_o;
  logic             done_o;
  logic [1:0]       status_o;
  logic             rewind_ip_o;
  logic             stop_trace_o;
  logic             cnt_wb_valid_o;
  logic [CNT_W-1:0] cnt_wb_o;

  int   n_tests;
  int   n_fail;
  int   iter;
  logic [15:0] zf_seq;
  logic [15:0] evt_seq;

  logic [1:0]       r_status;
  logic             r_wbv, r_rew, r_trc, r_seen;
  logic [CNT_W-1:0] r_cnt;

  rep_iter_ctrl #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .rep_code_i(rep_code_i),
    .cmp_op_i(cmp_op_i), .asize_i(asize_i), .count_i(count_i),
    .exec_req_o(exec_req_o), .exec_done_i(exec_done_i), .zf_i(zf_i),
    .event_pend_i(event_pend_i), .dbg_step_i(dbg_step_i), .busy_o(busy_o),
    .done_o(done_o), .status_o(status_o), .rewind_ip_o(rewind_ip_o),
    .stop_trace_o(stop_trace_o), .cnt_wb_valid_o(cnt_wb_valid_o),
    .cnt_wb_o(cnt_wb_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input logic ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Datapath responder: answers each request one cycle later.
  initial begin
    exec_done_i = 1'b0; zf_i = 1'b0; event_pend_i = 1'b0;
    forever begin
      @(negedge clk);
      if (exec_done_i) begin
        exec_done_i = 1'b0; zf_i = 1'b0; event_pend_i = 1'b0;
      end else if (exec_req_o) begin
        exec_done_i  = 1'b1;
        zf_i         = (iter < 16) ? zf_seq[iter[3:0]] : 1'b0;
        event_pend_i = (iter < 16) ? evt_seq[iter[3:0]] : 1'b0;
        iter++;
      end
    end
  end

  task automatic launch(input logic [1:0] code, input logic cmp,
                        input logic [1:0] as, input logic [63:0] cnt,
                        input logic [15:0] zs, input logic [15:0] es,
                        input logic dbg);
    @(negedge clk);
    iter = 0; zf_seq = zs; evt_seq = es; dbg_step_i = dbg;
    rep_code_i = code; cmp_op_i = cmp; asize_i = as; count_i = cnt;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_done;
    r_seen = 1'b0;
    for (int c = 0; c < 3000; c++) begin
      if (done_o) begin r_seen = 1'b1; break; end
      @(negedge clk);
    end
    r_status = status_o; r_wbv = cnt_wb_valid_o; r_cnt = cnt_wb_o;
    r_rew = rewind_ip_o; r_trc = stop_trace_o;
    @(negedge clk);
    dbg_step_i = 1'b0;
  endtask

  task automatic run(input logic [1:0] code, input logic cmp,
                     input logic [1:0] as, input logic [63:0] cnt,
                     input logic [15:0] zs, input logic [15:0] es,
                     input logic dbg);
    launch(code, cmp, as, cnt, zs, es, dbg);
    wait_done();
  endtask

  task automatic t_reset;
    check(!done_o && !busy_o && !exec_req_o, "R14 reset outputs idle",
          {61'd0, done_o, busy_o, exec_req_o}, 64'd0);
  endtask

  task automatic t_norep;
    run(2'd0, 1'b0, 2'd2, 64'd7, 16'h0, 16'h0, 1'b0);
    check(r_seen && iter == 1, "R1 single exec", iter, 1);
    check(!r_wbv && r_status == 2'd0, "R1 no writeback, completed",
          {r_wbv, r_status}, 0);
    check(!done_o, "R14 done single cycle", done_o, 0);
  endtask

  task automatic t_zero16;
    run(2'd1, 1'b0, 2'd0, 64'hABCD_0000_1234_0000, 16'h0, 16'h0, 1'b0);
    check(r_seen && iter == 0, "R2 zero count no exec", iter, 0);
    check(r_wbv && r_status == 2'd0 && r_cnt == 64'hABCD_0000_1234_0000,
          "R2 R4 count unchanged", r_cnt, 64'hABCD_0000_1234_0000);
  endtask

  task automatic t_plain64;
    run(2'd1, 1'b0, 2'd2, 64'd5, 16'h0, 16'h0, 1'b0);
    check(iter == 5, "R3 N iterations", iter, 5);
    check(r_cnt == 64'd0 && r_status == 2'd0, "R6 full count to zero", r_cnt, 0);
  endtask

  task automatic t_16wrap;
    run(2'd1, 1'b0, 2'd0, 64'hFFFF_FFFF_FFFF_0003, 16'h0, 16'h0, 1'b0);
    check(iter == 3, "R4 low field iterations", iter, 3);
    check(r_cnt == 64'hFFFF_FFFF_FFFF_0000, "R4 upper bits kept",
          r_cnt, 64'hFFFF_FFFF_FFFF_0000);
  endtask

  task automatic t_32ext;
    run(2'd1, 1'b0, 2'd1, 64'h1234_5678_0000_0002, 16'h0, 16'h0, 1'b0);
    check(iter == 2, "R5 32-bit iterations", iter, 2);
    check(r_cnt == 64'd0, "R5 zero-extended writeback", r_cnt, 0);
  endtask

  task automatic t_repe;
    run(2'd3, 1'b1, 2'd2, 64'd10, 16'h0007, 16'h0, 1'b0);
    check(iter == 4 && r_status == 2'd1, "R7 stop on ZF=0",
          {iter[61:0], r_status}, {62'd4, 2'd1});
    check(r_cnt == 64'd6, "R7 count after zf stop", r_cnt, 6);
    run(2'd3, 1'b0, 2'd2, 64'd3, 16'h0, 16'h0, 1'b0);
    check(iter == 3 && r_status == 2'd0, "R7 ZF ignored when not compare",
          {iter[61:0], r_status}, {62'd3, 2'd0});
  endtask

  task automatic t_repne;
    run(2'd2, 1'b1, 2'd2, 64'd10, 16'h0002, 16'h0, 1'b0);
    check(iter == 2 && r_status == 2'd1 && r_cnt == 64'd8, "R8 stop on ZF=1",
          r_cnt, 8);
  endtask

  task automatic t_zf_first;
    run(2'd3, 1'b1, 2'd2, 64'd2, 16'h0001, 16'h0, 1'b0);
    check(iter == 2 && r_status == 2'd1 && r_cnt == 64'd0,
          "R9 zf exit beats count exhausted", r_status, 1);
  endtask

  task automatic t_preempt;
    run(2'd1, 1'b0, 2'd2, 64'd6, 16'h0, 16'h0004, 1'b0);
    check(iter == 3 && r_cnt == 64'd3, "R10 preempt count", r_cnt, 3);
    check(r_status == 2'd2 && r_rew && r_trc, "R10 preempt flags",
          {r_status, r_rew, r_trc}, {2'd2, 1'b1, 1'b1});
  endtask

  task automatic t_evt_last;
    run(2'd1, 1'b0, 2'd2, 64'd2, 16'h0, 16'h0002, 1'b0);
    check(iter == 2 && r_status == 2'd0 && !r_rew && !r_trc,
          "R11 event on final iteration ignored", {r_status, r_rew, r_trc}, 0);
  endtask

  task automatic t_dbg;
    run(2'd1, 1'b0, 2'd2, 64'd4, 16'h0, 16'h0, 1'b1);
    check(iter == 1 && r_status == 2'd2 && r_cnt == 64'd3,
          "R12 debug step exits", r_cnt, 3);
  endtask

  task automatic t_busy;
    launch(2'd1, 1'b0, 2'd2, 64'd5, 16'h0, 16'h0, 1'b0);
    @(negedge clk); @(negedge clk);
    rep_code_i = 2'd0; count_i = 64'd1; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    wait_done();
    check(iter == 5 && r_cnt == 64'd0 && r_wbv, "R13 start ignored while busy",
          iter, 5);
  endtask

  initial begin
    n_tests = 0; n_fail = 0; iter = 0; zf_seq = '0; evt_seq = '0;
    start_i = 1'b0; rep_code_i = '0; cmp_op_i = 1'b0; asize_i = '0;
    count_i = '0; dbg_step_i = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset(); t_norep(); t_zero16(); t_plain64(); t_16wrap(); t_32ext();
    t_repe(); t_repne(); t_zf_first(); t_preempt(); t_evt_last(); t_dbg();
    t_busy();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule